// File: doc/BRIEF.md
# Table-Driven Rate-1/2 Convolutional Encoder

This block encodes a serial bit stream with a rate-1/2, nonsystematic, feedforward convolutional code. Each coded pair is not built from modulo-2 adder trees. It is read from a small writable parity table. The table index joins the encoder's stored history bits (the previous K-1 inputs) with the incoming bit. Each table word holds the two parity bits for that index.

The code can be changed at run time by rewriting the table through a simple write port. This lets another generator pair with the same constraint length replace the default one. The table size and index width stay fixed when this happens. A flush control feeds K-1 zero bits so that the trellis returns to the all-zero state. A synchronous reset clears the history and restores the default code.

Top module: `conv_lut_encoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `out_valid`, `out_pair` and `flush_active` to 0. It also empties the history to all zeros and reloads the default table.
- R2: `out_valid` is high in exactly the cycles that follow an encoded bit. A bit is encoded in a cycle with `in_valid` high and `flush_active` low, or in a flush cycle. While no bit is encoded, `out_pair` keeps its last value.
- R3: The index is `{history, bit}`. Index bit i carries the input delayed by i bits, so bit 0 is the new bit and bit K-1 is the oldest. `out_pair` shows the table word at that index. With the default table, `out_pair[0]` is the parity of taps 1 + D^3 + D^4 (mask 5'b11001) and `out_pair[1]` is the parity of taps 1 + D + D^3 + D^4 (mask 5'b11011).
- R4: Each encoded bit shifts the history left by one, and the new bit enters the least significant position. In cycles where no bit is encoded, the history does not change.
- R5: `tbl_we` with `in_valid` low and `flush_active` low writes `tbl_data` at index `tbl_addr`. The new word is used from the next encoded bit on. This holds for a full reload with another generator pair.
- R6: `tbl_we` in a cycle with `in_valid` high is ignored, and the table word stays unchanged.
- R7: `flush_req` with `flush_active` low starts a flush. In each of the next K-1 cycles, `flush_active` is high and a zero bit is encoded. After the flush, the history is all zeros.
- R8: `in_valid`, `in_bit` and `flush_req` are ignored while `flush_active` is high.
- R9: A reset applied after a table reload brings back the default generator pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Serial data bit |
| flush_req | input | 1 | Request a K-1 zero-bit tail |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | K | Table index to write |
| tbl_data | input | 2 | Parity word to write |
| out_valid | output | 1 | Coded pair valid |
| out_pair | output | 2 | Coded bits, bit 0 first generator |
| flush_active | output | 1 | Flush tail in progress |

## Verification
The cases hardest to reach from the ports are colliding controls. One is a table write that arrives together with an input bit and lands on the exact index the next bit will read. Another is an input bit presented while the flush tail runs. The bench computes the history in a shift-register-and-XOR reference model. From that it aims an out-of-turn write at the index of the following bit, holding a word that differs in both bits. It also drives data bits into the flush window. In both cases a wrong acceptance changes the compared coded pair. A full reload with a second generator pair is then streamed, and a reset after that reload checks that the default code comes back.

// File: rtl/conv_lut_pkg.sv
package conv_lut_pkg;

    typedef logic [1:0] pair_t;

    // Parity of an index against a tap mask; used only to build reset constants.
    function automatic pair_t tap_parity(input logic [31:0] idx,
                                         input logic [31:0] mask0,
                                         input logic [31:0] mask1,
                                         input int unsigned nbits);
        pair_t acc;
        acc = '0;
        for (int unsigned i = 0; i < nbits; i++) begin
            acc[0] = acc[0] ^ (idx[i] & mask0[i]);
            acc[1] = acc[1] ^ (idx[i] & mask1[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/conv_parity_table.sv
module conv_parity_table
    import conv_lut_pkg::*;
#(
    parameter int unsigned         K       = 5,
    parameter logic [K-1:0]        G0_MASK = 5'b11001,
    parameter logic [K-1:0]        G1_MASK = 5'b11011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [K-1:0] wr_idx,
    input  pair_t        wr_word,
    input  logic [K-1:0] rd_idx,
    output pair_t        rd_word
);
    localparam int unsigned DEPTH = 1 << K;

    pair_t mem_d [DEPTH];
    pair_t mem_q [DEPTH];
    pair_t dflt_w [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dflt
        assign dflt_w[gi] = tap_parity(32'(gi), 32'(G0_MASK), 32'(G1_MASK), K);
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = rst ? dflt_w[i] : mem_q[i];
        end
        if (!rst && wr_en) begin
            mem_d[wr_idx] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_idx];

endmodule

// File: rtl/conv_flush_ctrl.sv
module conv_flush_ctrl #(
    parameter int unsigned K = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic flush_req,
    output logic active
);
    localparam int unsigned TAIL = K - 1;
    localparam int unsigned CW   = $clog2(TAIL + 1);

    typedef struct packed {
        logic [CW-1:0] remain;
    } flush_t;

    flush_t f_d, f_q;

    assign active = (f_q.remain != '0);

    always_comb begin
        f_d = f_q;
        if (rst) begin
            f_d.remain = '0;
        end else if (active) begin
            f_d.remain = f_q.remain - 1'b1;
        end else if (flush_req) begin
            f_d.remain = CW'(TAIL);
        end
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

endmodule

// File: rtl/conv_lut_encoder.sv
module conv_lut_encoder
    import conv_lut_pkg::*;
#(
    parameter int unsigned  K       = 5,
    parameter logic [K-1:0] G0_MASK = 5'b11001,
    parameter logic [K-1:0] G1_MASK = 5'b11011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_bit,
    input  logic         flush_req,
    input  logic         tbl_we,
    input  logic [K-1:0] tbl_addr,
    input  logic [1:0]   tbl_data,
    output logic         out_valid,
    output logic [1:0]   out_pair,
    output logic         flush_active
);
    localparam int unsigned SW = K - 1;

    typedef struct packed {
        logic [SW-1:0] hist;
        logic          vld;
        pair_t         pair;
    } enc_t;

    enc_t r_d, r_q;

    logic          encode_w;
    logic          bit_w;
    logic [K-1:0]  idx_w;
    pair_t         word_w;
    logic          wr_ok_w;
    logic [SW-1:0] hist_w;

    conv_flush_ctrl #(.K(K)) flush_i (
        .clk       (clk),
        .rst       (rst),
        .flush_req (flush_req),
        .active    (flush_active)
    );

    assign encode_w = flush_active | in_valid;
    assign bit_w    = flush_active ? 1'b0 : in_bit;
    assign idx_w    = {r_q.hist, bit_w};
    assign wr_ok_w  = tbl_we & ~in_valid & ~flush_active;

    conv_parity_table #(.K(K), .G0_MASK(G0_MASK), .G1_MASK(G1_MASK)) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok_w),
        .wr_idx  (tbl_addr),
        .wr_word (tbl_data),
        .rd_idx  (idx_w),
        .rd_word (word_w)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (rst) begin
            r_d = '0;
        end else if (encode_w) begin
            r_d.vld  = 1'b1;
            r_d.pair = word_w;
            r_d.hist = {r_q.hist[SW-2:0], bit_w};
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign hist_w    = r_q.hist;
    assign out_valid = r_q.vld;
    assign out_pair  = r_q.pair;

endmodule

// File: rtl/conv_lut_encoder_chk.sv
module conv_lut_encoder_chk #(
    parameter int unsigned K = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_bit,
    input logic         flush_active,
    input logic         flush_req,
    input logic         out_valid,
    input logic [K-2:0] hist
);
    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid || flush_active) |=> out_valid); // R2
    AST_VALID_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid || flush_active)); // R2
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush_active) |=> hist == {$past(hist[K-3:0]), $past(in_bit)}); // R4
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush_active) |=> $stable(hist)); // R4
    AST_FLUSH_START: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_active) |-> $past(flush_req)); // R7
    AST_FLUSH_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        flush_active |=> (hist[0] == 1'b0)); // R8
    AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_active) |-> (hist == '0)); // R7
endmodule

bind conv_lut_encoder conv_lut_encoder_chk #(.K(K)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_bit       (in_bit),
    .flush_active (flush_active),
    .flush_req    (flush_req),
    .out_valid    (out_valid),
    .hist         (hist_w)
);

// File: tb/conv_lut_encoder_tb.sv
module conv_lut_encoder_tb_top;
    localparam int K     = 5;
    localparam int SW    = K - 1;
    localparam int DEPTH = 1 << K;
    localparam logic [K-1:0] DG0 = 5'b11001;
    localparam logic [K-1:0] DG1 = 5'b11011;
    localparam logic [K-1:0] AG0 = 5'b10111;
    localparam logic [K-1:0] AG1 = 5'b11101;

    // {flush_req, in_valid, in_bit}
    localparam int NSTIM = 24;
    localparam logic [2:0] STIM [NSTIM] = '{
        3'b011, 3'b010, 3'b011, 3'b011, 3'b000, 3'b010, 3'b011, 3'b010,
        3'b111, 3'b011, 3'b001, 3'b110, 3'b011, 3'b010, 3'b011, 3'b000,
        3'b011, 3'b011, 3'b011, 3'b011, 3'b100, 3'b000, 3'b000, 3'b010
    };

    logic clk = 1'b0;
    logic rst, in_valid, in_bit, flush_req, tbl_we;
    logic [K-1:0] tbl_addr;
    logic [1:0] tbl_data, out_pair;
    logic out_valid, flush_active;

    always #2.5 clk = ~clk;

    conv_lut_encoder #(.K(K)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .flush_req(flush_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .out_valid(out_valid), .out_pair(out_pair),
        .flush_active(flush_active)
    );

    int checks = 0;
    int failures = 0;
    logic [1:0]    mdl_tbl [DEPTH];
    logic [SW-1:0] mdl_hist;
    int            mdl_fcnt;
    logic          exp_v;
    logic [1:0]    exp_p;
    logic [15:0]   lf = 16'hACE1;

    function automatic logic par(input logic [K-1:0] a, input logic [K-1:0] m);
        return ^(a & m);
    endfunction

    task automatic load_mdl(input logic [K-1:0] g0, input logic [K-1:0] g1);
        for (int i = 0; i < DEPTH; i++) mdl_tbl[i] = {par(K'(i), g1), par(K'(i), g0)};
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic v, input logic b, input logic we,
                        input logic [K-1:0] a, input logic [1:0] d, input string tag);
        logic enc, bt;
        flush_req = f; in_valid = v; in_bit = b; tbl_we = we; tbl_addr = a; tbl_data = d;
        enc = (mdl_fcnt != 0) || v;
        bt  = (mdl_fcnt != 0) ? 1'b0 : b;
        if (we && !v && mdl_fcnt == 0) mdl_tbl[a] = d;
        exp_v = enc;
        if (enc) begin
            exp_p = mdl_tbl[{mdl_hist, bt}];
            mdl_hist = {mdl_hist[SW-2:0], bt};
        end
        if (mdl_fcnt != 0) mdl_fcnt--;
        else if (f) mdl_fcnt = K - 1;
        @(posedge clk);
        @(negedge clk);
        check("R2", "out_valid", 32'(out_valid), 32'(exp_v));
        check(tag, "out_pair", 32'(out_pair), 32'(exp_p));
        check("R7", "flush_active", 32'(flush_active), 32'(mdl_fcnt != 0));
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; in_valid = 0; in_bit = 0; flush_req = 0; tbl_we = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        load_mdl(DG0, DG1);
        mdl_hist = '0; mdl_fcnt = 0; exp_v = 0; exp_p = '0;
        check(tag, "out_valid after reset", 32'(out_valid), 0);
        check(tag, "out_pair after reset", 32'(out_pair), 0);
        check(tag, "flush_active after reset", 32'(flush_active), 0);
    endtask

    function automatic logic lfsr_bit();
        logic r;
        r  = lf[0];
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return r;
    endfunction

    initial begin
        logic [K-1:0] tgt;
        rst = 1'b1; in_valid = 0; in_bit = 0; flush_req = 0; tbl_we = 0;
        tbl_addr = '0; tbl_data = '0;
        @(negedge clk);
        do_reset("R1");

        // R3 R4 R7 R8: table walk with default code, flushes and idles
        for (int i = 0; i < NSTIM; i++)
            step(STIM[i][2], STIM[i][1], STIM[i][0], 1'b0, '0, '0, "R3");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, lfsr_bit(), 1'b0, '0, '0, "R3");

        // R4: idle cycles keep history
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R4");

        // R6: write colliding with an input, aimed at the next bit's index
        tgt = {mdl_hist[SW-2:0], 1'b0, 1'b1};
        step(1'b0, 1'b1, 1'b0, 1'b1, tgt, ~mdl_tbl[tgt], "R6");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, "R6");

        // R8: data and flush requests during a flush are dropped
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, "R8");
        for (int i = 0; i < K - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, "R8");

        // R5: full reload with another generator pair, then a stream
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 1'b0, 1'b1, K'(i),
                 {par(K'(i), AG1), par(K'(i), AG0)}, "R5");
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, lfsr_bit(), 1'b0, '0, '0, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R5");
        for (int i = 0; i < K - 1; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R5");

        // R5: single write used by the very next bit
        tgt = {mdl_hist, 1'b1};
        step(1'b0, 1'b0, 1'b0, 1'b1, tgt, ~mdl_tbl[tgt], "R5");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, "R5");

        // R9: reset after reload restores default code
        do_reset("R9");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, lfsr_bit(), 1'b0, '0, '0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule